// File: doc/BRIEF.md
# FSK Tag Identifier Waveform Generator

This block turns a 44-bit tag identifier into a coil drive sample stream that repeats without end. It is used to make a coil look like a low-frequency proximity tag. The identifier comes in as a high word and a low word. A start pulse checks the high word and, if it is in range, latches the identifier. From then on, every rising edge of an external field clock moves the output to the next sample of the frame. A sample of 1 leaves the coil open and a sample of 0 shorts it. The stop input ends the stream at once.

A frame has four parts, in this order:
- a short lead-in tone of one fc/8 period;
- a fixed start-of-frame marker made of eight tone bursts;
- the identifier bits, most significant first, each sent as a pair of bursts;
- a short fc/8 separator before each group of four bits.

Once the last bit has been sent, the stream goes back to the first sample of the frame.

The output side is a stream with a valid strobe and no ready. The field clock sets the pace, and the coil cannot wait, so there is no back-pressure. `sample_valid` pulses for one system clock each time `coil_open` takes a new sample. A consumer that cannot take every sample loses samples; the block never stalls.

Top module: `fsk_tag_waveform_gen`

## Requirements
- R1: Out of reset, `coil_open` is 1, `active` is 0 and `sample_valid` is 0. For as long as `active` is 0, `coil_open` stays 1.
- R2: A start pulse with `id_hi` at most 0xFFF sets `active` and latches the identifier. The first sample after that start is the lead-in tone 1,1,0,0,0,0,0,0.
- R3: An fc/8 burst is the pattern 1,1,0,0,0,0,0,0 sent six times, 48 samples in all. An fc/10 burst is the pattern 1,1,1,0,0,0,0,0,0,0 sent five times, 50 samples in all.
- R4: Straight after the lead-in tone comes the start-of-frame marker. It is the burst sequence fc8, fc8, fc8, fc10, fc10, fc10, fc8, fc10.
- R5: Each identifier bit is two bursts. A 1 is fc10 then fc8, and a 0 is fc8 then fc10. Bits go out from bit 43 down to bit 0. Bits 43..32 are `id_hi[11:0]` and bits 31..0 are `id_lo`.
- R6: One 8-sample separator (1,1,0,0,0,0,0,0) comes before each bit whose index modulo 4 is 3, that is before bits 43, 39, …, 3.
- R7: A frame is 4800 samples long. After the last sample, the stream goes back to sample 0 of the same frame.
- R8: Each rising edge of `field_clk` gives exactly one new sample and one `sample_valid` pulse. Between edges, `coil_open` does not change.
- R9: A start pulse with `id_hi` above 0xFFF is ignored. When idle, no output starts. When running, the current stream carries on unchanged.
- R10: When `stop` is asserted, `coil_open` is 1 and `active` is 0 on the next clock. `stop` wins over a `start` given in the same cycle.
- R11: An accepted start while the block is running drops the current frame. The next sample is sample 0 of a frame built from the new identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_clk | input | 1 | External field clock, asynchronous; each rising edge advances one sample |
| start | input | 1 | One-cycle pulse: check `id_hi`, latch the identifier, start from sample 0 |
| stop | input | 1 | Stops the stream and opens the coil |
| id_hi | input | 32 | High identifier word; only values up to 0xFFF are accepted |
| id_lo | input | 32 | Low identifier word (bits 31..0) |
| coil_open | output | 1 | Current sample: 1 = coil open, 0 = coil shorted |
| sample_valid | output | 1 | One-cycle strobe each time `coil_open` takes a new sample |
| active | output | 1 | High while a frame is being streamed |

## Verification
The bench builds the block with its default parameters:
- a 32-bit high-word input, which lets it drive values above the 12-bit limit so that rejection can be exercised;
- 12 and 32 identifier bits;
- bursts of six 8-sample periods and five 10-sample periods;
- groups of four bits.

With these values a frame is 4800 samples. That is short enough to stream two whole frames, a wrap past the frame boundary, and a restart in the middle of a frame. The field clock runs at about 4.6 system clocks per period and is not phase-aligned with the system clock, so the synchroniser sees edges at varying phases.

// File: rtl/fsk_gen_pkg.sv
package fsk_gen_pkg;

  typedef enum logic [1:0] {
    BK_SEP = 2'd0,
    BK_F8  = 2'd1,
    BK_F10 = 2'd2
  } burst_kind_t;

  typedef enum logic [2:0] {
    SQ_LEAD   = 3'd0,
    SQ_SOF    = 3'd1,
    SQ_GSEP   = 3'd2,
    SQ_HALF_A = 3'd3,
    SQ_HALF_B = 3'd4
  } seq_state_t;

endpackage

// File: rtl/fsk_field_sync.sv
module fsk_field_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);

  logic [STAGES-1:0] sr;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr[0] <= 1'b0;
    else        sr[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sr[g] <= 1'b0;
      else        sr[g] <= sr[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sr[STAGES-1];
  end

  assign rise_o = sr[STAGES-1] & ~prev_q;

  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/fsk_burst_gen.sv
module fsk_burst_gen
  import fsk_gen_pkg::*;
#(
  parameter int A_PERIOD = 8,
  parameter int A_HIGH   = 2,
  parameter int A_REPS   = 6,
  parameter int B_PERIOD = 10,
  parameter int B_HIGH   = 3,
  parameter int B_REPS   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        tick,
  input  burst_kind_t kind,
  output logic        sample_o,
  output logic        last_o
);

  localparam int MAXV  = (A_PERIOD > B_PERIOD ? A_PERIOD : B_PERIOD) >
                         (A_REPS > B_REPS ? A_REPS : B_REPS) ?
                         (A_PERIOD > B_PERIOD ? A_PERIOD : B_PERIOD) :
                         (A_REPS > B_REPS ? A_REPS : B_REPS);
  localparam int CNT_W = $clog2(MAXV + 1);

  logic [CNT_W-1:0] ph_q, rp_q;
  logic [CNT_W-1:0] per_m1, hi_lim, reps_m1;
  logic             ph_end;

  always_comb begin
    unique case (kind)
      BK_F10: begin
        per_m1  = CNT_W'(B_PERIOD - 1);
        hi_lim  = CNT_W'(B_HIGH);
        reps_m1 = CNT_W'(B_REPS - 1);
      end
      BK_F8: begin
        per_m1  = CNT_W'(A_PERIOD - 1);
        hi_lim  = CNT_W'(A_HIGH);
        reps_m1 = CNT_W'(A_REPS - 1);
      end
      default: begin
        per_m1  = CNT_W'(A_PERIOD - 1);
        hi_lim  = CNT_W'(A_HIGH);
        reps_m1 = '0;
      end
    endcase
  end

  assign ph_end   = (ph_q == per_m1);
  assign last_o   = ph_end && (rp_q == reps_m1);
  assign sample_o = (ph_q < hi_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ph_q <= '0;
      rp_q <= '0;
    end else if (tick) begin
      if (ph_end) begin
        ph_q <= '0;
        rp_q <= last_o ? '0 : rp_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= per_m1);
  a_r3_rep_range: assert property (@(posedge clk) disable iff (!rst_n)
    rp_q <= reps_m1);

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_gen_pkg::*;
#(
  parameter int               ID_W     = 44,
  parameter int               GROUP    = 4,
  parameter int               SOF_LEN  = 8,
  parameter logic [SOF_LEN-1:0] SOF_MASK = 8'hB8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            advance,
  input  logic [ID_W-1:0] id,
  output burst_kind_t     kind
);

  localparam int  BIT_W     = $clog2(ID_W);
  localparam int  SOF_W     = $clog2(SOF_LEN);
  localparam bit  FIRST_SEP = (((ID_W - 1) % GROUP) == (GROUP - 1));

  seq_state_t       st_q;
  logic [SOF_W-1:0] sof_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] nxt_bit;
  logic             grp_hit;
  logic             cur_bit;

  assign nxt_bit = bit_q - 1'b1;
  assign grp_hit = ((nxt_bit % BIT_W'(GROUP)) == BIT_W'(GROUP - 1));
  assign cur_bit = id[bit_q];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st_q  <= SQ_LEAD;
      sof_q <= '0;
      bit_q <= BIT_W'(ID_W - 1);
    end else if (advance) begin
      unique case (st_q)
        SQ_LEAD: begin
          st_q  <= SQ_SOF;
          sof_q <= '0;
        end
        SQ_SOF: begin
          if (sof_q == SOF_W'(SOF_LEN - 1)) begin
            bit_q <= BIT_W'(ID_W - 1);
            st_q  <= FIRST_SEP ? SQ_GSEP : SQ_HALF_A;
          end else begin
            sof_q <= sof_q + 1'b1;
          end
        end
        SQ_GSEP:   st_q <= SQ_HALF_A;
        SQ_HALF_A: st_q <= SQ_HALF_B;
        default: begin
          if (bit_q == '0) begin
            st_q  <= SQ_LEAD;
            bit_q <= BIT_W'(ID_W - 1);
          end else begin
            bit_q <= nxt_bit;
            st_q  <= grp_hit ? SQ_GSEP : SQ_HALF_A;
          end
        end
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_SOF:    kind = SOF_MASK[sof_q] ? BK_F10 : BK_F8;
      SQ_HALF_A: kind = cur_bit ? BK_F10 : BK_F8;
      SQ_HALF_B: kind = cur_bit ? BK_F8 : BK_F10;
      default:   kind = BK_SEP;
    endcase
  end

  a_r6_sep_before_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_GSEP && advance && !restart) |=> st_q == SQ_HALF_A);
  a_r7_wrap_to_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_HALF_B && advance && !restart && bit_q == '0) |=> st_q == SQ_LEAD);
  a_r5_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BIT_W'(ID_W - 1));

endmodule

// File: rtl/fsk_tag_waveform_gen.sv
module fsk_tag_waveform_gen
  import fsk_gen_pkg::*;
#(
  parameter int HI_IN_W     = 32,
  parameter int HI_W        = 12,
  parameter int LO_W        = 32,
  parameter int GROUP       = 4,
  parameter int A_PERIOD    = 8,
  parameter int A_HIGH      = 2,
  parameter int A_REPS      = 6,
  parameter int B_PERIOD    = 10,
  parameter int B_HIGH      = 3,
  parameter int B_REPS      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_clk,
  input  logic               start,
  input  logic               stop,
  input  logic [HI_IN_W-1:0] id_hi,
  input  logic [LO_W-1:0]    id_lo,
  output logic               coil_open,
  output logic               sample_valid,
  output logic               active
);

  localparam int               ID_W   = HI_W + LO_W;
  localparam logic [HI_IN_W-1:0] HI_MAX = HI_IN_W'((64'd1 << HI_W) - 1);

  logic            tick;
  logic            hi_ok, accept, adv;
  logic            smp, last;
  logic [ID_W-1:0] id_q;
  burst_kind_t     kind;

  assign hi_ok  = (id_hi <= HI_MAX);
  assign accept = start && !stop && hi_ok;
  assign adv    = active && tick && !stop && !accept;

  fsk_field_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (field_clk),
    .rise_o(tick)
  );

  fsk_frame_seq #(
    .ID_W (ID_W),
    .GROUP(GROUP)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(accept),
    .advance(adv && last),
    .id     (id_q),
    .kind   (kind)
  );

  fsk_burst_gen #(
    .A_PERIOD(A_PERIOD), .A_HIGH(A_HIGH), .A_REPS(A_REPS),
    .B_PERIOD(B_PERIOD), .B_HIGH(B_HIGH), .B_REPS(B_REPS)
  ) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .tick    (adv),
    .kind    (kind),
    .sample_o(smp),
    .last_o  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      coil_open    <= 1'b1;
      sample_valid <= 1'b0;
      id_q         <= '0;
    end else if (stop) begin
      active       <= 1'b0;
      coil_open    <= 1'b1;
      sample_valid <= 1'b0;
    end else if (accept) begin
      active       <= 1'b1;
      id_q         <= {id_hi[HI_W-1:0], id_lo};
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= adv;
      if (adv) coil_open <= smp;
    end
  end

  a_r1_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> coil_open);
  a_r10_stop_opens: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (coil_open && !active && !sample_valid));
  a_r9_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hi_ok && !active) |=> !active);
  a_r8_no_tick_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !sample_valid);
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop) |=> $stable(coil_open));

endmodule

// File: tb/fsk_tag_waveform_gen_test.sv
module fsk_tag_waveform_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int FIELD_HALF = 23;
  localparam int WD_LIMIT   = 150000;
  localparam int FRAME_LEN  = 8 + 4*48 + 4*50 + 44*98 + 11*8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_clk = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [31:0] id_hi = '0;
  logic [31:0] id_lo = '0;
  logic        coil_open, sample_valid, active;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(FIELD_HALF) field_clk = ~field_clk;

  fsk_tag_waveform_gen uut (
    .clk(clk), .rst_n(rst_n), .field_clk(field_clk),
    .start(start), .stop(stop), .id_hi(id_hi), .id_lo(id_lo),
    .coil_open(coil_open), .sample_valid(sample_valid), .active(active)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    frame_v[FRAME_LEN];
  string frame_t[FRAME_LEN];
  int    wp;
  bit    count_en = 0;
  int    field_edges = 0;
  int    valids = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input bit v, input string t);
    frame_v[wp] = v;
    frame_t[wp] = t;
    wp++;
  endtask

  task automatic put_burst(input int per, input int hi, input int reps, input string t);
    for (int r = 0; r < reps; r++)
      for (int p = 0; p < per; p++) put(p < hi, t);
  endtask

  // Expected frame from the requirements: R2 lead-in, R4 marker, R6 separators, R5/R3 bits
  task automatic build_frame(input logic [11:0] hi, input logic [31:0] lo);
    logic [43:0] id;
    id = {hi, lo};
    wp = 0;
    put_burst(8, 2, 1, "R2");
    put_burst(8, 2, 6, "R4/R3");
    put_burst(8, 2, 6, "R4/R3");
    put_burst(8, 2, 6, "R4/R3");
    put_burst(10, 3, 5, "R4/R3");
    put_burst(10, 3, 5, "R4/R3");
    put_burst(10, 3, 5, "R4/R3");
    put_burst(8, 2, 6, "R4/R3");
    put_burst(10, 3, 5, "R4/R3");
    for (int b = 43; b >= 0; b--) begin
      if (b % 4 == 3) put_burst(8, 2, 1, "R6");
      if (id[b]) begin
        put_burst(10, 3, 5, "R5/R3");
        put_burst(8, 2, 6, "R5/R3");
      end else begin
        put_burst(8, 2, 6, "R5/R3");
        put_burst(10, 3, 5, "R5/R3");
      end
    end
  endtask

  task automatic push_range(input int from, input int to, input string over);
    for (int i = from; i < to; i++) begin
      exp_q.push_back(frame_v[i]);
      tag_q.push_back(over == "" ? frame_t[i] : over);
    end
  endtask

  // Monitor: pops and compares one expected sample per strobe
  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      if (count_en) valids++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected sample", 1, 0);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(coil_open == e, t, int'(coil_open), int'(e));
      end
    end
  end

  always @(posedge field_clk) if (count_en) field_edges++;

  task automatic pulse_start(input logic [31:0] hi, input logic [31:0] lo);
    id_hi = hi;
    id_lo = lo;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic run_main();
    int d;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(coil_open == 1'b1, "R1 coil", int'(coil_open), 1);
    check(active == 1'b0, "R1 active", int'(active), 0);
    check(sample_valid == 1'b0, "R1 valid", int'(sample_valid), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R9: out-of-range high word while idle
    pulse_start(32'h0000_1000, 32'h1);
    repeat (30) @(negedge clk);
    check(active == 1'b0, "R9 idle reject active", int'(active), 0);
    check(coil_open == 1'b1, "R9 idle reject coil", int'(coil_open), 1);

    // R10: stop wins over start in the same cycle
    id_hi = 32'h5;
    start = 1'b1;
    stop  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop  = 1'b0;
    repeat (20) @(negedge clk);
    check(active == 1'b0, "R10 stop over start", int'(active), 0);

    // Frame 1: full frame plus wrap (R7)
    build_frame(12'hA5C, 32'h1234_5678);
    push_range(0, FRAME_LEN, "");
    push_range(0, 100, "R7");
    field_edges = 0;
    valids = 0;
    pulse_start(32'h0000_0A5C, 32'h1234_5678);
    count_en = 1;
    check(active == 1'b1, "R2 active after start", int'(active), 1);
    wait_drain();
    stop = 1'b1;
    count_en = 0;
    d = field_edges - valids;
    check(d >= -2 && d <= 2, "R8 edges vs samples", valids, field_edges);
    @(negedge clk);
    stop = 1'b0;
    check(coil_open == 1'b1, "R10 coil open", int'(coil_open), 1);
    check(active == 1'b0, "R10 inactive", int'(active), 0);
    repeat (30) @(negedge clk);
    check(coil_open == 1'b1, "R10 stays open", int'(coil_open), 1);

    // Frame 2, with a rejected start while running (R9), then restart (R11)
    build_frame(12'h000, 32'hFFFF_FFFF);
    push_range(0, 600, "");
    pulse_start(32'h0, 32'hFFFF_FFFF);
    while (exp_q.size() > 300) @(negedge clk);
    pulse_start(32'h0001_0000, 32'h0);
    check(active == 1'b1, "R9 running unaffected", int'(active), 1);
    wait_drain();
    build_frame(12'hFFF, 32'h0);
    push_range(0, 50, "R11");
    push_range(50, FRAME_LEN, "");
    pulse_start(32'h0000_0FFF, 32'h0);
    wait_drain();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(active == 1'b0, "R10 final stop", int'(active), 0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (WD_LIMIT) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule